// File: doc/BRIEF.md
# JTAG Register Access Scan Chain

This block is a test-access-port data register through which an external debugger reads and writes a small bank of 32-bit registers. It sits behind a standard TAP controller and follows that controller's capture, shift and update strobes, all timed on TCK. A 40-bit frame is shifted through TDI/TDO. Once the frame is updated, the block turns it into a single write or read access on a simple parallel bus made of address, write data, a write strobe, a read strobe and returned read data.

Reads are split across two scans. The first scan places an address and requests the read. The read data comes back in the data field of the next scan's frame. The bus read strobe is what drives side effects behind the bus: reading the trace-RAM data location (address 4) pops one entry. A debugger that drains that location therefore ends with a scan aimed at a harmless address such as 0. The block only answers when the access instruction is loaded and register chain 0 has been chosen. Chain choice is a separate 5-bit register, shifted while the chain-select instruction is loaded.

Top module: `jtag_reg_access`

## Requirements
- R1: While `trst_n` is low, and in the first cycle after it rises, `reg_wr`, `reg_rd` and `tdo` are 0 and the selected chain is 31.
- R2: Frame layout: bits 31:0 hold data, bits 38:32 hold the address and bit 39 is the direction flag. `tdo` always shows bit 0 of the frame. On each shift cycle the frame moves one place toward bit 0 and `tdi` enters at bit 39, so the data LSB leaves first.
- R3: An update with flag 1 and an address from 4 to 8 gives exactly one `reg_wr` cycle, in the cycle after the update. In that cycle `reg_addr` and `reg_wdata` equal the frame's address and data fields.
- R4: An update with flag 1 and an address from 0 to 3, or above 8, gives no `reg_wr`. The addressed register keeps its value.
- R5: An update with flag 0 and an address from 0 to 8 gives exactly one `reg_rd` cycle, in the cycle after the update, with `reg_addr` set to that address. A run of reads of address 4 ended by a read of address 0 returns consecutive trace-RAM entries and pops exactly once per address-4 scan.
- R6: The next capture loads the frame with the read data in the data field, the last updated address in the address field, and flag 0.
- R7: A read update of an address above 8 gives no `reg_rd`. The next capture returns zero data.
- R8: The first capture after a write update, whether or not the write was accepted, returns zero data.
- R9: A capture that lands in the same cycle as `reg_rd` loads the live `reg_rdata` into the data field.
- R10: Capture, shift and update take effect only when `ir_code` is 0xC and the selected chain is 0. When `ir_code` is neither 0xC nor 0x2, `tdo` is 0.
- R11: While `ir_code` is 0x2, a 5-bit select register shifts LSB first from `tdi` and drives `tdo` from its bit 0. Its value becomes the selected chain on update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| ir_code | input | 4 | Currently loaded TAP instruction |
| capture_dr | input | 1 | TAP in capture state this cycle |
| shift_dr | input | 1 | TAP in shift state this cycle |
| update_dr | input | 1 | TAP in update state this cycle |
| reg_addr | output | 7 | Register address on the parallel bus |
| reg_wdata | output | 32 | Write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 32 | Read data for `reg_addr`, combinational |

## Verification
The read strobe for one scan and the capture that opens the next scan can fall in the same TCK cycle if the controller goes straight from update to capture. In that case the value latched from the bus and the value loaded into the frame compete. The bench provokes this by running a read scan with no gap cycle before the next capture. It then checks that the following scan returns exactly the register's value, and its per-cycle model predicts the live bypass independently. The normal path, with a one-cycle gap, is run alongside it. The trace-RAM drain sequence is also run, to show that neither path adds or loses a pop.

// File: rtl/jra_pkg.sv
package jra_pkg;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_dir_e;

  // true when a lies inside [lo, hi]
  function automatic logic in_window(int unsigned a, int unsigned lo, int unsigned hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/jra_chain_sel.sv
module jra_chain_sel #(
  parameter int SEL_W = 5
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             en,
  input  logic             shift_en,
  input  logic             update_en,
  input  logic             tdi,
  output logic [SEL_W-1:0] chain_q,
  output logic             sel_tdo
);

  logic [SEL_W-1:0] sel_sr;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sel_sr  <= '1;
      chain_q <= '1;
    end else if (en) begin
      if (shift_en)  sel_sr  <= {tdi, sel_sr[SEL_W-1:1]};
      if (update_en) chain_q <= sel_sr;
    end
  end

  assign sel_tdo = sel_sr[0];

endmodule

// File: rtl/jra_shift_reg.sv
module jra_shift_reg #(
  parameter int TOT_W = 40
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             shift_en,
  input  logic             tdi,
  input  logic [TOT_W-1:0] load_val,
  output logic [TOT_W-1:0] q,
  output logic             so
);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (load_en)  q <= load_val;
    else if (shift_en) q <= {tdi, q[TOT_W-1:1]};
  end

  assign so = q[0];

endmodule

// File: rtl/jra_access_ctrl.sv
module jra_access_ctrl #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 7,
  parameter int NUM_REGS = 9,
  parameter int FIRST_WR = 4,
  localparam int TOT_W   = DATA_W + ADDR_W + 1
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [TOT_W-1:0]  frame,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [DATA_W-1:0] cap_data
);
  import jra_pkg::*;

  localparam int unsigned LAST_REG = NUM_REGS - 1;

  logic [DATA_W-1:0] f_data;
  logic [ADDR_W-1:0] f_addr;
  acc_dir_e          f_dir;
  logic              wr_ok, rd_ok;
  logic [DATA_W-1:0] held;

  assign f_data = frame[DATA_W-1:0];
  assign f_addr = frame[DATA_W +: ADDR_W];
  assign f_dir  = acc_dir_e'(frame[TOT_W-1]);

  assign wr_ok = upd_en && (f_dir == ACC_WRITE) &&
                 in_window(int'(f_addr), FIRST_WR, LAST_REG);
  assign rd_ok = upd_en && (f_dir == ACC_READ) &&
                 in_window(int'(f_addr), 0, LAST_REG);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_wr    <= 1'b0;
      bus_rd    <= 1'b0;
      held      <= '0;
    end else begin
      bus_wr <= wr_ok;
      bus_rd <= rd_ok;
      if (upd_en) begin
        bus_addr  <= f_addr;
        bus_wdata <= f_data;
      end
      if (upd_en && !rd_ok) held <= '0;
      else if (bus_rd)      held <= bus_rdata;
    end
  end

  // live bypass when the capture meets the read strobe
  assign cap_data = bus_rd ? bus_rdata : held;

endmodule

// File: rtl/jtag_reg_access.sv
module jtag_reg_access #(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 7,
  parameter int SEL_W        = 5,
  parameter int IR_W         = 4,
  parameter int NUM_REGS     = 9,
  parameter int FIRST_WR     = 4,
  parameter logic [IR_W-1:0]  ACCESS_IR    = 4'hC,
  parameter logic [IR_W-1:0]  SELECT_IR    = 4'h2,
  parameter logic [SEL_W-1:0] TARGET_CHAIN = '0
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  output logic              tdo,
  input  logic [IR_W-1:0]   ir_code,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);

  localparam int TOT_W = DATA_W + ADDR_W + 1;

  logic             sel_en, acc_en;
  logic [SEL_W-1:0] chain_q;
  logic             sel_tdo, sr_tdo;
  logic [TOT_W-1:0] sr_q, cap_frame;
  logic [DATA_W-1:0] cap_data;

  assign sel_en = (ir_code == SELECT_IR);
  assign acc_en = (ir_code == ACCESS_IR) && (chain_q == TARGET_CHAIN);

  jra_chain_sel #(.SEL_W(SEL_W)) u_sel (
    .tck(tck), .rst_n(trst_n), .en(sel_en), .shift_en(shift_dr),
    .update_en(update_dr), .tdi(tdi), .chain_q(chain_q), .sel_tdo(sel_tdo)
  );

  assign cap_frame = {1'b0, reg_addr, cap_data};

  jra_shift_reg #(.TOT_W(TOT_W)) u_sr (
    .tck(tck), .rst_n(trst_n), .load_en(acc_en && capture_dr),
    .shift_en(acc_en && shift_dr), .tdi(tdi), .load_val(cap_frame),
    .q(sr_q), .so(sr_tdo)
  );

  jra_access_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .FIRST_WR(FIRST_WR)
  ) u_acc (
    .tck(tck), .rst_n(trst_n), .upd_en(acc_en && update_dr), .frame(sr_q),
    .bus_rdata(reg_rdata), .bus_addr(reg_addr), .bus_wdata(reg_wdata),
    .bus_wr(reg_wr), .bus_rd(reg_rd), .cap_data(cap_data)
  );

  assign tdo = sel_en ? sel_tdo : (acc_en ? sr_tdo : 1'b0);

endmodule

// File: rtl/jtag_reg_access_chk.sv
module jtag_reg_access_chk #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 7,
  parameter int IR_W     = 4,
  parameter int NUM_REGS = 9,
  parameter int FIRST_WR = 4,
  parameter logic [IR_W-1:0] ACCESS_IR = 4'hC,
  parameter logic [IR_W-1:0] SELECT_IR = 4'h2,
  localparam int TOT_W = DATA_W + ADDR_W + 1
) (
  input logic              tck,
  input logic              trst_n,
  input logic              tdo,
  input logic [IR_W-1:0]   ir_code,
  input logic              capture_dr,
  input logic              update_dr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              acc_en,
  input logic [TOT_W-1:0]  sr_q
);

  p_wr_follows_update_r3: assert property (@(posedge tck) disable iff (!trst_n)
    reg_wr |-> $past(update_dr));

  p_update_takes_addr_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (update_dr && acc_en) |=> (reg_addr == $past(sr_q[DATA_W +: ADDR_W])));

  p_wr_window_r4: assert property (@(posedge tck) disable iff (!trst_n)
    reg_wr |-> (int'(reg_addr) >= FIRST_WR && int'(reg_addr) < NUM_REGS));

  p_rd_single_r5: assert property (@(posedge tck) disable iff (!trst_n)
    reg_rd |=> !reg_rd);

  p_no_wr_rd_r5: assert property (@(posedge tck) disable iff (!trst_n)
    !(reg_wr && reg_rd));

  p_rd_window_r7: assert property (@(posedge tck) disable iff (!trst_n)
    reg_rd |-> (int'(reg_addr) < NUM_REGS));

  p_live_capture_r9: assert property (@(posedge tck) disable iff (!trst_n)
    (capture_dr && acc_en && reg_rd) |=> (sr_q[DATA_W-1:0] == $past(reg_rdata)));

  p_quiet_tdo_r10: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_code != ACCESS_IR && ir_code != SELECT_IR) |-> !tdo);

endmodule

bind jtag_reg_access jtag_reg_access_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IR_W(IR_W), .NUM_REGS(NUM_REGS),
  .FIRST_WR(FIRST_WR), .ACCESS_IR(ACCESS_IR), .SELECT_IR(SELECT_IR)
) u_chk (
  .tck(tck), .trst_n(trst_n), .tdo(tdo), .ir_code(ir_code),
  .capture_dr(capture_dr), .update_dr(update_dr), .reg_addr(reg_addr),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
  .acc_en(acc_en), .sr_q(sr_q)
);

// File: tb/jtag_reg_access_bench.sv
module jtag_reg_access_bench;

  logic tck = 1'b0;
  always #2 tck = ~tck;

  logic        trst_n = 1'b0, tdi = 1'b0, cap = 1'b0, sh = 1'b0, upd = 1'b0;
  logic [3:0]  ir = 4'hC;
  wire         tdo, reg_wr, reg_rd;
  wire  [6:0]  reg_addr;
  wire  [31:0] reg_wdata;
  logic [31:0] reg_rdata;

  jtag_reg_access u_jtag_reg_access (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .tdo(tdo), .ir_code(ir),
    .capture_dr(cap), .shift_dr(sh), .update_dr(upd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // register bank behind the bus: 4 pops trace RAM, 5 is its read pointer
  logic [31:0] bank [0:8];
  logic [31:0] ram  [0:15];
  int          rptr = 0;
  logic        s_wr = 0, s_rd = 0;
  logic [6:0]  s_addr = 0;
  logic [31:0] s_wdata = 0, s_rdata = 0;

  initial begin
    for (int i = 0; i < 9; i++)  bank[i] = 32'hA500_0000 + i * 32'h111;
    for (int k = 0; k < 16; k++) ram[k]  = 32'hD000_0000 + k * 17;
  end

  always_comb begin
    if (reg_addr == 7'd4)      reg_rdata = ram[rptr[3:0]];
    else if (reg_addr == 7'd5) reg_rdata = rptr;
    else if (reg_addr < 7'd9)  reg_rdata = bank[reg_addr[3:0]];
    else                       reg_rdata = 32'hBAD0_BAD0;
  end

  always @(posedge tck) begin
    if (s_wr) begin
      if (s_addr == 7'd5) rptr <= s_wdata;
      else bank[s_addr[3:0]] <= s_wdata;
    end
    if (s_rd && s_addr == 7'd4) rptr <= rptr + 1;
  end

  // behavioural reference, stepped on each rising edge
  bit          mq[$];
  bit          mselq[$];
  int          mchain;
  logic [31:0] mhold, capd, fd;
  logic [6:0]  mlast, fa;
  bit          e_we, e_re, pre_re, act, ff;
  logic [6:0]  e_addr;
  logic [31:0] e_wdata;

  always @(posedge tck) begin
    if (!trst_n) begin
      mq.delete(); for (int i = 0; i < 40; i++) mq.push_back(1'b0);
      mselq.delete(); for (int i = 0; i < 5; i++) mselq.push_back(1'b1);
      mchain = 31; mhold = 0; mlast = 0;
      e_we = 0; e_re = 0; e_addr = 0; e_wdata = 0;
    end else begin
      pre_re = e_re; e_we = 0; e_re = 0;
      capd = pre_re ? s_rdata : mhold;
      if (pre_re) mhold = s_rdata;
      if (ir == 4'h2) begin
        if (sh) begin void'(mselq.pop_front()); mselq.push_back(tdi); end
        if (upd) begin
          mchain = 0;
          for (int i = 0; i < 5; i++) if (mselq[i]) mchain += (1 << i);
        end
      end
      act = (ir == 4'hC) && (mchain == 0);
      if (act) begin
        if (cap) begin
          mq.delete();
          for (int i = 0; i < 32; i++) mq.push_back(capd[i]);
          for (int i = 0; i < 7; i++)  mq.push_back(mlast[i]);
          mq.push_back(1'b0);
        end else if (sh) begin
          void'(mq.pop_front()); mq.push_back(tdi);
        end else if (upd) begin
          for (int i = 0; i < 32; i++) fd[i] = mq[i];
          for (int i = 0; i < 7; i++)  fa[i] = mq[32 + i];
          ff = mq[39];
          mlast = fa; e_addr = fa; e_wdata = fd;
          if (ff) begin
            if (fa >= 4 && fa <= 8) e_we = 1;
            mhold = 0;
          end else if (fa <= 8) e_re = 1;
          else mhold = 0;
        end
      end
    end
  end

  int          wr_cnt = 0, rd_cnt = 0;
  logic [6:0]  last_wa = 0;
  logic [31:0] last_wd = 0;
  bit          e_tdo;

  // per-cycle comparison, well away from the rising edge
  always @(negedge tck) begin
    #1;
    if (trst_n) begin
      chk(reg_wr == e_we, "R3", "write strobe", reg_wr, e_we);
      chk(reg_rd == e_re, "R5", "read strobe", reg_rd, e_re);
      if (e_we || e_re) chk(reg_addr == e_addr, "R5", "bus address", reg_addr, e_addr);
      if (e_we) chk(reg_wdata == e_wdata, "R3", "write data", reg_wdata, e_wdata);
      if (ir == 4'h2) e_tdo = mselq[0];
      else if (ir == 4'hC && mchain == 0) e_tdo = mq[0];
      else e_tdo = 1'b0;
      chk(tdo == e_tdo, "R2", "tdo", tdo, e_tdo);
      if (reg_wr) begin wr_cnt++; last_wa = reg_addr; last_wd = reg_wdata; end
      if (reg_rd) rd_cnt++;
    end
    s_wr = reg_wr; s_rd = reg_rd; s_addr = reg_addr; s_wdata = reg_wdata; s_rdata = reg_rdata;
  end

  function automatic logic [39:0] frm(bit wr, logic [6:0] a, logic [31:0] d);
    return {wr, a, d};
  endfunction

  task automatic scan(input logic [39:0] v, input int gap, output logic [39:0] got);
    cap = 1;
    @(negedge tck);
    cap = 0;
    for (int i = 0; i < 40; i++) begin
      sh = 1; tdi = v[i];
      #1 got[i] = tdo;
      @(negedge tck);
    end
    sh = 0; upd = 1;
    @(negedge tck);
    upd = 0;
    repeat (gap) @(negedge tck);
  endtask

  task automatic select_chain(input logic [4:0] c, output logic [4:0] got);
    ir = 4'h2;
    @(negedge tck);
    for (int i = 0; i < 5; i++) begin
      sh = 1; tdi = c[i];
      #1 got[i] = tdo;
      @(negedge tck);
    end
    sh = 0; upd = 1;
    @(negedge tck);
    upd = 0; ir = 4'hC;
    @(negedge tck);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge tck);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [39:0] g;
    logic [4:0]  gs;
    int          c0;
    repeat (3) @(negedge tck);
    #1;
    chk(reg_wr == 0, "R1", "reset write strobe", reg_wr, 0);
    chk(reg_rd == 0, "R1", "reset read strobe", reg_rd, 0);
    chk(tdo == 0, "R1", "reset tdo", tdo, 0);
    @(negedge tck);
    trst_n = 1;
    @(negedge tck);
    #1 chk(reg_wr == 0 && reg_rd == 0, "R1", "strobes after reset", {reg_wr, reg_rd}, 0);
    @(negedge tck);

    // R10: chain not yet chosen, access instruction has no effect
    scan(frm(1, 7'd8, 32'h0000_0055), 1, g);
    repeat (2) @(negedge tck);
    chk(wr_cnt == 0, "R10", "write with chain unselected", wr_cnt, 0);
    chk(g == 0, "R10", "tdo with chain unselected", g, 0);
    ir = 4'h5;
    scan(frm(1, 7'd8, 32'hFFFF_FFFF), 1, g);
    chk(g == 0 && wr_cnt == 0, "R10", "other instruction", g, 0);

    // R11: chain select shows its reset content then takes 0
    select_chain(5'd0, gs);
    chk(gs == 5'h1F, "R11", "select register shifted out", gs, 5'h1F);

    // R3: accepted write
    scan(frm(1, 7'd8, 32'h1234_5678), 1, g);
    @(negedge tck);
    chk(wr_cnt == 1 && last_wa == 8 && last_wd == 32'h1234_5678, "R3", "write to 8",
        {wr_cnt[15:0], 9'd0, last_wa, last_wd}, {16'd1, 9'd0, 7'd8, 32'h1234_5678});

    // R4: read-only and out-of-range writes dropped
    scan(frm(1, 7'd2, 32'hDEAD_BEEF), 1, g);
    scan(frm(1, 7'd12, 32'hDEAD_BEEF), 1, g);
    chk(wr_cnt == 1, "R4", "dropped writes", wr_cnt, 1);
    scan(frm(0, 7'd2, 32'h0), 1, g);
    chk(g[31:0] == 0, "R8", "capture after write", g[31:0], 0);
    scan(frm(0, 7'd0, 32'h0), 1, g);
    chk(g[31:0] == 32'hA500_0222, "R4", "read-only register kept", g[31:0], 32'hA500_0222);

    // R6 / R2: full frame order of a read result
    scan(frm(0, 7'd1, 32'h0), 1, g);
    scan(frm(0, 7'd0, 32'h0), 1, g);
    chk(g == {1'b0, 7'd1, 32'hA500_0111}, "R6", "returned frame", g, {1'b0, 7'd1, 32'hA500_0111});
    chk(g[0] == 1'b1 && g[39] == 1'b0, "R2", "data lsb first, flag last", {g[39], g[0]}, 2'b01);

    // R7: read above the bank
    c0 = rd_cnt;
    scan(frm(0, 7'd9, 32'h0), 1, g);
    @(negedge tck);
    chk(rd_cnt == c0, "R7", "no read strobe above bank", rd_cnt, c0);
    scan(frm(0, 7'd0, 32'h0), 1, g);
    chk(g[31:0] == 0, "R7", "zero data above bank", g[31:0], 0);

    // R5: draining trace RAM, one pop per scan, final harmless address
    scan(frm(1, 7'd5, 32'd0), 1, g);
    c0 = rd_cnt;
    scan(frm(0, 7'd4, 32'h0), 1, g);
    for (int k = 0; k < 3; k++) begin
      scan(frm(0, 7'd4, 32'h0), 1, g);
      chk(g[31:0] == 32'hD000_0000 + k * 17, "R5", "trace entry", g[31:0], 32'hD000_0000 + k * 17);
    end
    scan(frm(0, 7'd0, 32'h0), 1, g);
    chk(g[31:0] == 32'hD000_0000 + 3 * 17, "R5", "last trace entry", g[31:0], 32'hD000_0000 + 51);
    scan(frm(0, 7'd5, 32'h0), 1, g);
    scan(frm(0, 7'd0, 32'h0), 1, g);
    chk(g[31:0] == 4, "R5", "read pointer after drain", g[31:0], 4);
    chk(rd_cnt == c0 + 7, "R5", "read strobe count", rd_cnt, c0 + 7);

    // R9: capture in the same cycle as the read strobe
    scan(frm(0, 7'd8, 32'h0), 0, g);
    scan(frm(0, 7'd0, 32'h0), 1, g);
    chk(g[31:0] == 32'h1234_5678, "R9", "live capture", g[31:0], 32'h1234_5678);

    repeat (3) @(negedge tck);
    finish_run();
  end

endmodule